// File: doc/BRIEF.md
# Fault aggregation and interrupt reporter

This block gathers fault and warning flags from a set of load-switch channels and from the supply and serial-link monitors, and turns them into sticky status bits that software clears by reading. Each channel has its own status byte. A 16-bit global word summarises the channels and holds the supply and link events. An active-low interrupt line is pulled low while any fault that is allowed to interrupt, and is not masked, is pending. The upper byte of the global word is presented as a status header that the serial shifter returns at the start of every frame.

Every event input is a level flag from an asynchronous detector. It passes through a synchroniser, and a status bit is set for every cycle its synchronised level is high, so even a single-cycle pulse is captured. A status bit clears only when its register is read and its condition is gone. Some events are qualified: off-state open load and output short to supply are selected by a 2-bit per-channel field, the watchdog error by an enable, and the CRC error by a CRC-check enable. While low-power mode is active the interrupt line stays released, and pending faults appear on it once the mode ends.

Top module: `fault_reporter`

## Requirements
- R1: While reset is asserted and after it is released, every channel status byte reads 0x00 and the global word reads 0x8008. Only the power-on bit (bit 3) and the error/warning summary (bit 15) are set, and the interrupt line goes low one clock after reset is released.
- R2: A status bit stays set until its register is read (rd_ch[c] for channel c, rd_glob for global bits 5:0) in a cycle where its synchronised condition is low. A read while the condition is present has no effect, and a set in the same cycle as a read wins.
- R3: An over-temperature warning sets channel bit 0 and the channel summary bit (global bit 8+c) and does not pull the interrupt low.
- R4: A thermal shutdown (channel bit 1), an overcurrent trip or inrush-timer expiry (channel bit 2), or an I2T trip (channel bit 3, plus channel-fault bit 5) sets the channel summary bit and the shared shutdown bit (global bit 14), and pulls the interrupt low.
- R5: Off-state open load is reported only when offst_sel for the channel is 2'b10, and output short to supply only when it is 2'b01. Either one sets channel bit 4, the channel summary bit and global bit 13, and pulls the interrupt low unless mask_off[c] is 1.
- R6: A supply warning (global bit 0) and a logic-supply undervoltage (bit 1) set the error/warning bit 15 without interrupt. A battery undervoltage (bit 2) also pulls the interrupt low.
- R7: A watchdog error sets global bit 4 only when wd_en is 1. A frame error always sets link-error bit 5, and a CRC error sets it only when crc_en is 1. Each sets bit 15 and pulls the interrupt low unless mask_wd or mask_link is 1.
- R8: A retrying channel sets channel-fault bit 5. A latched-off channel sets bits 5 and 6. Both pull the interrupt low, and neither sets global bits.
- R9: While lpm is 1 the interrupt output is 1. Faults that arrive during low-power mode are still latched and pull the interrupt low one clock after lpm returns to 0.
- R10: hdr always equals bits 15:8 of the global word.
- R11: A one-cycle event pulse shows in its status bit SYNC_STAGES+1 rising edges after it is sampled, and on the interrupt one edge later.
- R12: The power-on bit is set by reset and cleared by the first global read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lpm | input | 1 | Low-power mode active |
| ev_hot_warn | input | NCH | Over-temperature warning per channel |
| ev_hot_off | input | NCH | Thermal shutdown per channel |
| ev_ovc_trip | input | NCH | Immediate overcurrent trip per channel |
| ev_inrush_to | input | NCH | Current-limit inrush timer expired per channel |
| ev_i2t_trip | input | NCH | I2T shutdown per channel |
| ev_open_load | input | NCH | Off-state open load per channel |
| ev_out_short | input | NCH | Output shorted to supply per channel |
| ev_retry | input | NCH | Channel waiting to retry |
| ev_latched | input | NCH | Channel latched off |
| offst_sel | input | 2*NCH | Off-state report select per channel (01 short, 10 open load) |
| ev_sup_warn | input | 1 | Supply undervoltage warning |
| ev_logic_uv | input | 1 | Logic-supply undervoltage lockout |
| ev_batt_uv | input | 1 | Battery undervoltage lockout |
| ev_wdog | input | 1 | Serial watchdog error |
| ev_frame | input | 1 | Serial frame error |
| ev_crc | input | 1 | Serial CRC error |
| wd_en | input | 1 | Watchdog reporting enable |
| crc_en | input | 1 | CRC checking enable |
| mask_off | input | NCH | Interrupt mask for off-state faults per channel |
| mask_wd | input | 1 | Interrupt mask for watchdog error |
| mask_link | input | 1 | Interrupt mask for link errors |
| rd_glob | input | 1 | Global word read strobe |
| rd_ch | input | NCH | Channel status read strobes |
| irq_n | output | 1 | Active-low interrupt, 1 means released |
| hdr | output | 8 | Status header for each serial frame |
| glob_word | output | 16 | Global fault word |
| ch_stat | output | 8*NCH | Channel status bytes, channel c at [8c+7:8c] |

## Verification
A stuck or wrongly cleared sticky bit shows at the ports one edge after the read strobe: glob_word or the matching ch_stat byte keeps a bit it should have dropped, or drops one it should have kept. The interrupt line shows the same error one edge later. A wrong qualifier, mode decode or mask shows SYNC_STAGES+2 edges after the event, as a status bit or an interrupt that should not be there, or that is missing. Because the header is a slice of the global word, any summary error is visible both in the word and in the frame header.

// File: rtl/fault_rpt_pkg.sv
package fault_rpt_pkg;

  // channel status byte layout
  localparam int CB_HOT_WARN = 0;
  localparam int CB_HOT_OFF  = 1;
  localparam int CB_OVC      = 2;
  localparam int CB_I2T      = 3;
  localparam int CB_OFFST    = 4;
  localparam int CB_CHFLT    = 5;
  localparam int CB_LATCH    = 6;
  localparam int CB_STICKY   = 7;
  localparam int CH_BYTE     = 8;

  // global word layout
  localparam int GB_SUP_WARN = 0;
  localparam int GB_LOGIC_UV = 1;
  localparam int GB_BATT_UV  = 2;
  localparam int GB_POR      = 3;
  localparam int GB_WDOG     = 4;
  localparam int GB_LINK     = 5;
  localparam int GB_STICKY   = 6;
  localparam int GB_CHSUM    = 8;
  localparam int GB_OFFST    = 13;
  localparam int GB_SHUTDN   = 14;
  localparam int GB_ERRWRN   = 15;
  localparam int GLOB_W      = 16;
  localparam int MAX_CH      = 4;

  // off-state report select codes
  localparam logic [1:0] OFFSEL_SHORT = 2'b01;
  localparam logic [1:0] OFFSEL_OPEN  = 2'b10;

  typedef struct packed {
    logic latched;
    logic retry;
    logic out_short;
    logic open_load;
    logic i2t_trip;
    logic inrush_to;
    logic ovc_trip;
    logic hot_off;
    logic hot_warn;
  } ch_ev_t;

  typedef struct packed {
    logic crc;
    logic frame;
    logic wdog;
    logic batt_uv;
    logic logic_uv;
    logic sup_warn;
  } gl_ev_t;

endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/fr_sticky.sv
module fr_sticky #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] cond,
  input  logic         rd,
  output logic [W-1:0] q
);

  logic [W-1:0] bit_q;
  logic [W-1:0] bit_d;
  logic [W-1:0] bit_en;

  // a set always wins over a coincident read
  always_comb begin
    bit_en = set | ({W{rd}} & ~cond);
    bit_d  = set;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q[i] <= RST_VAL[i];
      end else if (bit_en[i]) begin
        bit_q[i] <= bit_d[i];
      end
    end
  end

  assign q = bit_q;

endmodule

// File: rtl/fr_chan.sv
module fr_chan
  import fault_rpt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  ch_ev_t                ev,
  input  logic [1:0]            offst_sel,
  input  logic                  mask_off,
  input  logic                  rd,
  output logic [CH_BYTE-1:0]    stat,
  output logic                  summary,
  output logic                  shutdn,
  output logic                  offst,
  output logic                  pend
);

  logic [CB_STICKY-1:0] set_v;
  logic [CB_STICKY-1:0] st_q;
  logic                 off_hit;

  always_comb begin
    off_hit = (ev.open_load && (offst_sel == OFFSEL_OPEN)) ||
              (ev.out_short && (offst_sel == OFFSEL_SHORT));
    set_v              = '0;
    set_v[CB_HOT_WARN] = ev.hot_warn;
    set_v[CB_HOT_OFF]  = ev.hot_off;
    set_v[CB_OVC]      = ev.ovc_trip | ev.inrush_to;
    set_v[CB_I2T]      = ev.i2t_trip;
    set_v[CB_OFFST]    = off_hit;
    set_v[CB_CHFLT]    = ev.retry | ev.latched | ev.i2t_trip;
    set_v[CB_LATCH]    = ev.latched;
  end

  fr_sticky #(.W(CB_STICKY), .RST_VAL('0)) u_st (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (set_v),
    .cond (set_v),
    .rd   (rd),
    .q    (st_q)
  );

  always_comb begin
    stat                 = '0;
    stat[CB_STICKY-1:0]  = st_q;
    summary = st_q[CB_HOT_WARN] | st_q[CB_HOT_OFF] | st_q[CB_OVC] |
              st_q[CB_I2T] | st_q[CB_OFFST];
    shutdn  = st_q[CB_HOT_OFF] | st_q[CB_OVC] | st_q[CB_I2T];
    offst   = st_q[CB_OFFST];
    pend    = shutdn | st_q[CB_CHFLT] | st_q[CB_LATCH] |
              (st_q[CB_OFFST] & ~mask_off);
  end

endmodule

// File: rtl/fr_glob.sv
module fr_glob
  import fault_rpt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  gl_ev_t               ev,
  input  logic                 wd_en,
  input  logic                 crc_en,
  input  logic                 mask_wd,
  input  logic                 mask_link,
  input  logic                 rd,
  output logic [GB_STICKY-1:0] stat,
  output logic                 pend
);

  localparam logic [GB_STICKY-1:0] POR_VAL = GB_STICKY'(1) << GB_POR;

  logic [GB_STICKY-1:0] set_v;

  always_comb begin
    set_v              = '0;
    set_v[GB_SUP_WARN] = ev.sup_warn;
    set_v[GB_LOGIC_UV] = ev.logic_uv;
    set_v[GB_BATT_UV]  = ev.batt_uv;
    set_v[GB_POR]      = 1'b0;
    set_v[GB_WDOG]     = ev.wdog & wd_en;
    set_v[GB_LINK]     = ev.frame | (ev.crc & crc_en);
  end

  fr_sticky #(.W(GB_STICKY), .RST_VAL(POR_VAL)) u_st (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (set_v),
    .cond (set_v),
    .rd   (rd),
    .q    (stat)
  );

  always_comb begin
    pend = stat[GB_BATT_UV] | stat[GB_POR] |
           (stat[GB_WDOG] & ~mask_wd) | (stat[GB_LINK] & ~mask_link);
  end

endmodule

// File: rtl/fault_reporter.sv
module fault_reporter
  import fault_rpt_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lpm,
  input  logic [NCH-1:0]     ev_hot_warn,
  input  logic [NCH-1:0]     ev_hot_off,
  input  logic [NCH-1:0]     ev_ovc_trip,
  input  logic [NCH-1:0]     ev_inrush_to,
  input  logic [NCH-1:0]     ev_i2t_trip,
  input  logic [NCH-1:0]     ev_open_load,
  input  logic [NCH-1:0]     ev_out_short,
  input  logic [NCH-1:0]     ev_retry,
  input  logic [NCH-1:0]     ev_latched,
  input  logic [2*NCH-1:0]   offst_sel,
  input  logic               ev_sup_warn,
  input  logic               ev_logic_uv,
  input  logic               ev_batt_uv,
  input  logic               ev_wdog,
  input  logic               ev_frame,
  input  logic               ev_crc,
  input  logic               wd_en,
  input  logic               crc_en,
  input  logic [NCH-1:0]     mask_off,
  input  logic               mask_wd,
  input  logic               mask_link,
  input  logic               rd_glob,
  input  logic [NCH-1:0]     rd_ch,
  output logic               irq_n,
  output logic [7:0]         hdr,
  output logic [15:0]        glob_word,
  output logic [8*NCH-1:0]   ch_stat
);

  localparam int CH_EV_W = $bits(ch_ev_t);
  localparam int GL_EV_W = $bits(gl_ev_t);

  ch_ev_t [NCH-1:0] ch_raw;
  ch_ev_t [NCH-1:0] ch_syn;
  gl_ev_t           gl_raw;
  gl_ev_t           gl_syn;

  logic [NCH-1:0]       ch_sum;
  logic [NCH-1:0]       ch_shut;
  logic [NCH-1:0]       ch_off;
  logic [NCH-1:0]       ch_pend;
  logic [GB_STICKY-1:0] gl_stat;
  logic                 gl_pend;
  logic                 irq_d;
  logic                 irq_q;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_raw[c].hot_warn  = ev_hot_warn[c];
      ch_raw[c].hot_off   = ev_hot_off[c];
      ch_raw[c].ovc_trip  = ev_ovc_trip[c];
      ch_raw[c].inrush_to = ev_inrush_to[c];
      ch_raw[c].i2t_trip  = ev_i2t_trip[c];
      ch_raw[c].open_load = ev_open_load[c];
      ch_raw[c].out_short = ev_out_short[c];
      ch_raw[c].retry     = ev_retry[c];
      ch_raw[c].latched   = ev_latched[c];
    end
    gl_raw.sup_warn = ev_sup_warn;
    gl_raw.logic_uv = ev_logic_uv;
    gl_raw.batt_uv  = ev_batt_uv;
    gl_raw.wdog     = ev_wdog;
    gl_raw.frame    = ev_frame;
    gl_raw.crc      = ev_crc;
  end

  fr_sync #(.W(CH_EV_W*NCH), .STAGES(SYNC_STAGES)) u_sync_ch (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ch_raw),
    .q    (ch_syn)
  );

  fr_sync #(.W(GL_EV_W), .STAGES(SYNC_STAGES)) u_sync_gl (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (gl_raw),
    .q    (gl_syn)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    fr_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ch_syn[c]),
      .offst_sel(offst_sel[2*c +: 2]),
      .mask_off (mask_off[c]),
      .rd       (rd_ch[c]),
      .stat     (ch_stat[CH_BYTE*c +: CH_BYTE]),
      .summary  (ch_sum[c]),
      .shutdn   (ch_shut[c]),
      .offst    (ch_off[c]),
      .pend     (ch_pend[c])
    );
  end

  fr_glob u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (gl_syn),
    .wd_en    (wd_en),
    .crc_en   (crc_en),
    .mask_wd  (mask_wd),
    .mask_link(mask_link),
    .rd       (rd_glob),
    .stat     (gl_stat),
    .pend     (gl_pend)
  );

  // global word assembly; channel summaries occupy up to MAX_CH bits
  always_comb begin
    glob_word                  = '0;
    glob_word[GB_STICKY-1:0]   = gl_stat;
    for (int c = 0; c < NCH && c < MAX_CH; c++) begin
      glob_word[GB_CHSUM + c]  = ch_sum[c];
    end
    glob_word[GB_OFFST]        = |ch_off;
    glob_word[GB_SHUTDN]       = |ch_shut;
    glob_word[GB_ERRWRN]       = |gl_stat;
  end

  assign hdr = glob_word[15:8];

  // interrupt line: low drives the pad, high releases it
  always_comb begin
    irq_d = ~((|ch_pend | gl_pend) & ~lpm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b1;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_n = irq_q;

endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lpm,
  input logic             irq_n,
  input logic             rd_glob,
  input logic [NCH-1:0]   rd_ch,
  input logic [15:0]      glob_word,
  input logic [8*NCH-1:0] ch_stat
);

  // R9
  lpm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lpm) |-> irq_n);

  // R2
  glob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_glob |=> ((glob_word[5:0] & $past(glob_word[5:0])) == $past(glob_word[5:0])));

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past((|ch_stat) || (|glob_word[5:0])));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R2
    ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ch[c] |=> ((ch_stat[8*c +: 8] & $past(ch_stat[8*c +: 8])) == $past(ch_stat[8*c +: 8])));
  end

endmodule

bind fault_reporter fr_chk #(.NCH(NCH)) u_fr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lpm      (lpm),
  .irq_n    (irq_n),
  .rd_glob  (rd_glob),
  .rd_ch    (rd_ch),
  .glob_word(glob_word),
  .ch_stat  (ch_stat)
);

// File: tb/test_fault_reporter.sv
module test_fault_reporter;

  localparam int NCH = 2;

  logic clk, rst_n, lpm;
  logic [NCH-1:0] ev_hot_warn, ev_hot_off, ev_ovc_trip, ev_inrush_to, ev_i2t_trip;
  logic [NCH-1:0] ev_open_load, ev_out_short, ev_retry, ev_latched;
  logic [2*NCH-1:0] offst_sel;
  logic ev_sup_warn, ev_logic_uv, ev_batt_uv, ev_wdog, ev_frame, ev_crc;
  logic wd_en, crc_en, mask_wd, mask_link, rd_glob;
  logic [NCH-1:0] mask_off, rd_ch;
  logic irq_n;
  logic [7:0] hdr;
  logic [15:0] glob_word;
  logic [8*NCH-1:0] ch_stat;

  int n_vec, n_bad;
  bit done;

  fault_reporter #(.NCH(NCH), .SYNC_STAGES(2)) i_fault_reporter (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // cev: 0 hot_warn 1 hot_off 2 ovc 3 inrush 4 i2t 5 open 6 short 7 retry 8 latched
  // gev: 0 sup_warn 1 logic_uv 2 batt_uv 3 wdog 4 frame 5 crc
  // msk: 0 mask_off 1 mask_wd 2 mask_link ; irq = 1 means interrupt expected low
  typedef struct packed {
    logic       ch;
    logic [8:0] cev;
    logic [1:0] sel;
    logic [5:0] gev;
    logic       wde;
    logic       crce;
    logic [2:0] msk;
    logic [7:0] xch;
    logic [15:0] xgl;
    logic       xirq;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 9'h001, 2'b00, 6'h00, 1'b0, 1'b0, 3'b000, 8'h01, 16'h0100, 1'b0, 4'd3},  // R3
    '{1'b0, 9'h002, 2'b00, 6'h00, 1'b0, 1'b0, 3'b000, 8'h02, 16'h4100, 1'b1, 4'd4},  // R4
    '{1'b1, 9'h004, 2'b00, 6'h00, 1'b0, 1'b0, 3'b000, 8'h04, 16'h4200, 1'b1, 4'd4},  // R4
    '{1'b0, 9'h008, 2'b00, 6'h00, 1'b0, 1'b0, 3'b000, 8'h04, 16'h4100, 1'b1, 4'd4},  // R4
    '{1'b0, 9'h010, 2'b00, 6'h00, 1'b0, 1'b0, 3'b000, 8'h28, 16'h4100, 1'b1, 4'd4},  // R4
    '{1'b0, 9'h020, 2'b10, 6'h00, 1'b0, 1'b0, 3'b000, 8'h10, 16'h2100, 1'b1, 4'd5},  // R5
    '{1'b0, 9'h020, 2'b01, 6'h00, 1'b0, 1'b0, 3'b000, 8'h00, 16'h0000, 1'b0, 4'd5},  // R5
    '{1'b1, 9'h040, 2'b01, 6'h00, 1'b0, 1'b0, 3'b000, 8'h10, 16'h2200, 1'b1, 4'd5},  // R5
    '{1'b0, 9'h040, 2'b10, 6'h00, 1'b0, 1'b0, 3'b000, 8'h00, 16'h0000, 1'b0, 4'd5},  // R5
    '{1'b0, 9'h020, 2'b10, 6'h00, 1'b0, 1'b0, 3'b001, 8'h10, 16'h2100, 1'b0, 4'd5},  // R5
    '{1'b0, 9'h080, 2'b00, 6'h00, 1'b0, 1'b0, 3'b000, 8'h20, 16'h0000, 1'b1, 4'd8},  // R8
    '{1'b1, 9'h100, 2'b00, 6'h00, 1'b0, 1'b0, 3'b000, 8'h60, 16'h0000, 1'b1, 4'd8},  // R8
    '{1'b0, 9'h000, 2'b00, 6'h01, 1'b0, 1'b0, 3'b000, 8'h00, 16'h8001, 1'b0, 4'd6},  // R6
    '{1'b0, 9'h000, 2'b00, 6'h02, 1'b0, 1'b0, 3'b000, 8'h00, 16'h8002, 1'b0, 4'd6},  // R6
    '{1'b0, 9'h000, 2'b00, 6'h04, 1'b0, 1'b0, 3'b000, 8'h00, 16'h8004, 1'b1, 4'd6},  // R6
    '{1'b0, 9'h000, 2'b00, 6'h08, 1'b0, 1'b0, 3'b000, 8'h00, 16'h0000, 1'b0, 4'd7},  // R7
    '{1'b0, 9'h000, 2'b00, 6'h08, 1'b1, 1'b0, 3'b000, 8'h00, 16'h8010, 1'b1, 4'd7},  // R7
    '{1'b0, 9'h000, 2'b00, 6'h08, 1'b1, 1'b0, 3'b010, 8'h00, 16'h8010, 1'b0, 4'd7},  // R7
    '{1'b0, 9'h000, 2'b00, 6'h10, 1'b0, 1'b0, 3'b000, 8'h00, 16'h8020, 1'b1, 4'd7},  // R7
    '{1'b0, 9'h000, 2'b00, 6'h20, 1'b0, 1'b0, 3'b000, 8'h00, 16'h0000, 1'b0, 4'd7},  // R7
    '{1'b0, 9'h000, 2'b00, 6'h20, 1'b0, 1'b1, 3'b000, 8'h00, 16'h8020, 1'b1, 4'd7},  // R7
    '{1'b0, 9'h000, 2'b00, 6'h10, 1'b0, 1'b0, 3'b100, 8'h00, 16'h8020, 1'b0, 4'd7}   // R7
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_hot_warn = '0; ev_hot_off = '0; ev_ovc_trip = '0; ev_inrush_to = '0;
    ev_i2t_trip = '0; ev_open_load = '0; ev_out_short = '0; ev_retry = '0;
    ev_latched = '0; ev_sup_warn = 0; ev_logic_uv = 0; ev_batt_uv = 0;
    ev_wdog = 0; ev_frame = 0; ev_crc = 0;
  endtask

  task automatic read_all();
    rd_glob = 1; rd_ch = '1;
    tick(1);
    rd_glob = 0; rd_ch = '0;
    tick(2);
  endtask

  task automatic chk_clean(string req);
    chk(ch_stat == '0, req, 16'(ch_stat), 16'h0);
    chk(glob_word == 16'h0, req, glob_word, 16'h0);
    chk(irq_n == 1'b1, req, 16'(irq_n), 16'h1);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 0; lpm = 0; idle_inputs();
    offst_sel = '0; wd_en = 0; crc_en = 0; mask_off = '0; mask_wd = 0; mask_link = 0;
    rd_glob = 0; rd_ch = '0;
    tick(2);
    // R1 state during reset
    chk(glob_word == 16'h8008, "R1", glob_word, 16'h8008);
    chk(irq_n == 1'b1, "R1", 16'(irq_n), 16'h1);
    rst_n = 1;
    tick(2);
    // R1 / R12 after release
    chk(glob_word == 16'h8008, "R12", glob_word, 16'h8008);
    chk(ch_stat == '0, "R1", 16'(ch_stat), 16'h0);
    chk(hdr == 8'h80, "R10", 16'(hdr), 16'h80);
    chk(irq_n == 1'b0, "R1", 16'(irq_n), 16'h0);
    read_all();
    chk_clean("R12");

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.rq, i);
      offst_sel[2*int'(v.ch) +: 2] = v.sel;
      wd_en = v.wde; crc_en = v.crce;
      mask_off[v.ch] = v.msk[0]; mask_wd = v.msk[1]; mask_link = v.msk[2];
      ev_hot_warn[v.ch] = v.cev[0]; ev_hot_off[v.ch] = v.cev[1];
      ev_ovc_trip[v.ch] = v.cev[2]; ev_inrush_to[v.ch] = v.cev[3];
      ev_i2t_trip[v.ch] = v.cev[4]; ev_open_load[v.ch] = v.cev[5];
      ev_out_short[v.ch] = v.cev[6]; ev_retry[v.ch] = v.cev[7];
      ev_latched[v.ch] = v.cev[8];
      ev_sup_warn = v.gev[0]; ev_logic_uv = v.gev[1]; ev_batt_uv = v.gev[2];
      ev_wdog = v.gev[3]; ev_frame = v.gev[4]; ev_crc = v.gev[5];
      tick(1);
      idle_inputs();
      tick(5);
      chk(ch_stat[8*int'(v.ch) +: 8] == v.xch, tag, 16'(ch_stat[8*int'(v.ch) +: 8]), 16'(v.xch));
      chk(glob_word == v.xgl, tag, glob_word, v.xgl);
      chk(irq_n == !v.xirq, tag, 16'(irq_n), 16'(!v.xirq));
      // R10
      chk(hdr == v.xgl[15:8], "R10", 16'(hdr), 16'(v.xgl[15:8]));
      read_all();
      chk_clean(tag);
      offst_sel = '0; wd_en = 0; crc_en = 0; mask_off = '0; mask_wd = 0; mask_link = 0;
    end

    // R2: read while condition present has no effect
    ev_hot_off[0] = 1;
    tick(5);
    rd_ch[0] = 1; tick(1); rd_ch[0] = 0; tick(2);
    chk(ch_stat[1] == 1'b1, "R2 read while present", 16'(ch_stat[7:0]), 16'h02);
    chk(irq_n == 1'b0, "R2 irq kept", 16'(irq_n), 16'h0);
    ev_hot_off[0] = 0;
    tick(5);
    chk(ch_stat[7:0] == 8'h02, "R2 no read no clear", 16'(ch_stat[7:0]), 16'h02);
    // R2: new event coincides with read, set wins
    ev_hot_off[0] = 1; tick(1);
    ev_hot_off[0] = 0; tick(1);
    rd_ch[0] = 1; tick(1); rd_ch[0] = 0;
    tick(2);
    chk(ch_stat[7:0] == 8'h02, "R2 set beats read", 16'(ch_stat[7:0]), 16'h02);
    rd_ch[0] = 1; tick(1); rd_ch[0] = 0; tick(2);
    chk_clean("R2 clear after gone");

    // R9: low-power mode holds the line released
    lpm = 1;
    ev_ovc_trip[1] = 1; tick(1); ev_ovc_trip[1] = 0;
    tick(6);
    chk(ch_stat[15:8] == 8'h04, "R9 latched in lpm", 16'(ch_stat[15:8]), 16'h04);
    chk(irq_n == 1'b1, "R9 released in lpm", 16'(irq_n), 16'h1);
    lpm = 0;
    tick(1);
    chk(irq_n == 1'b0, "R9 after lpm exit", 16'(irq_n), 16'h0);
    read_all();
    chk_clean("R9");

    // R11: latency of a single-cycle pulse
    ev_hot_off[1] = 1; tick(1);
    ev_hot_off[1] = 0; tick(1);
    chk(ch_stat[9] == 1'b0, "R11 not yet", 16'(ch_stat[15:8]), 16'h00);
    tick(1);
    chk(ch_stat[9] == 1'b1, "R11 status edge", 16'(ch_stat[15:8]), 16'h02);
    chk(irq_n == 1'b1, "R11 irq not yet", 16'(irq_n), 16'h1);
    tick(1);
    chk(irq_n == 1'b0, "R11 irq edge", 16'(irq_n), 16'h0);
    read_all();
    chk_clean("R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule